// File: doc/BRIEF.md
# Delay-Code Controller with Lock Detect and Clock-Gate Enable

This block is the digital control loop of an all-digital delay-locked loop. On every reference clock edge it reads an early/late decision from the phase detector and moves a binary delay code one step up or down. Each bit of that code switches in a capacitor of matching binary weight on every delay stage, so one step changes the stage delay by one least-significant unit.

When the decisions start to alternate, the loop is dithering around the aligned point. The controller then freezes its code, declares lock and drops the enable of the clock gate in front of its own counter. The frozen code register keeps the value through this sleep period. Once every wake period the gate opens for a single edge so that one decision can be sampled. Two wake samples in a row that ask for the same direction show that the phase has drifted, so the controller leaves lock and resumes stepping. A hold request from outside freezes the loop at any time.

Top module: `dll_code_ctrl`

## Requirements
- R1: While rst_n is low, dly_code is mid-scale (8'h80, only the top bit set), locked is 0 and gate_en is 1.
- R2: When unlocked, with hold_req low and pd_valid high, a rising clk_ref edge raises dly_code by one if pd_up is 1 and lowers it by one if pd_up is 0.
- R3: dly_code saturates: an up step at 8'hFF leaves 8'hFF, a down step at 8'h00 leaves 8'h00, and the code never wraps.
- R4: A clk_ref edge with pd_valid low changes neither dly_code nor the lock state.
- R5: While hold_req is high, dly_code, locked and the wake timer stay frozen and gate_en is 0.
- R6: A valid decision counts as an alternation when it differs from the previous valid decision. On the edge that brings the 4th alternation in a row, locked rises; that edge still applies its step. A repeated direction restarts the count.
- R7: While locked, dly_code does not change, and gate_en is 1 for exactly one edge in every 64, the wake edge, and 0 otherwise.
- R8: When two consecutive wake edges with pd_valid high both carry the same pd_up, locked falls on the second one. From the next edge on, the code steps again, starting from the value held during lock.
- R9: gate_en is updated on the falling edge of clk_ref only, and so it never changes while clk_ref is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; the code changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_valid | input | 1 | Phase-detector decision is valid on this edge |
| pd_up | input | 1 | Decision: 1 asks for more delay, 0 for less |
| hold_req | input | 1 | Freeze the loop at its present state |
| dly_code | output | 8 | Binary-weighted capacitor select for the delay stages |
| locked | output | 1 | Loop is aligned and the code is frozen |
| gate_en | output | 1 | Enable for the counter's integrated clock gate, updated on the falling edge |

## Verification
A corrupted alternation count shows up as lock being declared early or late. The locked output therefore differs from the reference model on the edge that should have locked, and the code keeps or stops stepping one edge later. A wrong wake timer shows within one 64-edge period as a gate_en pulse in the wrong cycle, or as a missing one. A step or saturation fault shows in dly_code on the very next rising edge. Because the model is compared on every cycle, each of these faults is reported in the first cycle it appears, not at the end of a phase.

// File: rtl/dll_ctrl_pkg.sv
package dll_ctrl_pkg;

   typedef enum logic {
      DIR_DN = 1'b0,
      DIR_UP = 1'b1
   } pd_dir_e;

   function automatic int unsigned width_of(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

endpackage

// File: rtl/dll_code_step.sv
module dll_code_step
   import dll_ctrl_pkg::*;
#(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              dir_up,
   output logic [CODE_W-1:0] code
);

   localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_MIN = {CODE_W{1'b0}};
   localparam logic [CODE_W-1:0] ONE      = {{(CODE_W-1){1'b0}}, 1'b1};

   logic at_edge;
   logic [CODE_W-1:0] code_nxt;

   always_comb begin
      at_edge  = (dir_up == DIR_UP) ? (code == CODE_MAX) : (code == CODE_MIN);
      code_nxt = (dir_up == DIR_UP) ? code + ONE : code - ONE;
   end

   // The enabled register doubles as the retention element during sleep.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= CODE_MID;
      end else if (step_en && !at_edge) begin
         code <= code_nxt;
      end
   end

endmodule

// File: rtl/dll_lock_det.sv
module dll_lock_det
   import dll_ctrl_pkg::*;
#(
   parameter int unsigned LOCK_ALT = 4,
   parameter int unsigned WAKE_PER = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic pd_valid,
   input  logic pd_up,
   output logic locked,
   output logic wake_now
);

   localparam int unsigned AW = width_of(LOCK_ALT);
   localparam int unsigned WW = width_of(WAKE_PER);
   localparam logic [AW-1:0] ALT_LAST  = AW'(LOCK_ALT - 1);
   localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_PER - 1);
   localparam logic [AW-1:0] ALT_ONE   = AW'(1);
   localparam logic [WW-1:0] WAKE_ONE  = WW'(1);

   logic          last_dir;
   logic          have_last;
   logic [AW-1:0] alt_cnt;
   logic [WW-1:0] wake_cnt;
   logic          wake_dir;
   logic          wake_have;
   logic          is_alt;
   logic          is_repeat;

   always_comb begin
      wake_now  = locked && (wake_cnt == WAKE_LAST);
      is_alt    = have_last && (pd_up != last_dir);
      is_repeat = wake_have && (pd_up == wake_dir);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked    <= 1'b0;
         last_dir  <= DIR_DN;
         have_last <= 1'b0;
         alt_cnt   <= '0;
         wake_cnt  <= '0;
         wake_dir  <= DIR_DN;
         wake_have <= 1'b0;
      end else if (run) begin
         if (!locked) begin
            if (pd_valid) begin
               last_dir  <= pd_up;
               have_last <= 1'b1;
               if (is_alt) begin
                  if (alt_cnt == ALT_LAST) begin
                     locked    <= 1'b1;
                     alt_cnt   <= '0;
                     wake_cnt  <= '0;
                     wake_have <= 1'b0;
                  end else begin
                     alt_cnt <= alt_cnt + ALT_ONE;
                  end
               end else begin
                  alt_cnt <= '0;
               end
            end
         end else begin
            wake_cnt <= wake_now ? '0 : wake_cnt + WAKE_ONE;
            if (wake_now && pd_valid) begin
               if (is_repeat) begin
                  locked    <= 1'b0;
                  wake_have <= 1'b0;
                  have_last <= 1'b0;
                  alt_cnt   <= '0;
               end else begin
                  wake_dir  <= pd_up;
                  wake_have <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/dll_gate_reg.sv
module dll_gate_reg #(
   parameter bit LOW_PHASE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_nxt,
   output logic gate_en
);

   generate
      if (LOW_PHASE) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) gate_en <= 1'b1;
            else        gate_en <= en_nxt;
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gate_en <= 1'b1;
            else        gate_en <= en_nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/dll_code_ctrl.sv
module dll_code_ctrl #(
   parameter int unsigned CODE_W   = 8,
   parameter int unsigned LOCK_ALT = 4,
   parameter int unsigned WAKE_PER = 64
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic              pd_valid,
   input  logic              pd_up,
   input  logic              hold_req,
   output logic [CODE_W-1:0] dly_code,
   output logic              locked,
   output logic              gate_en
);

   initial begin
      if (CODE_W < 2)   $error("CODE_W must be at least 2");
      if (LOCK_ALT < 1) $error("LOCK_ALT must be at least 1");
      if (WAKE_PER < 2) $error("WAKE_PER must be at least 2");
   end

   logic run;
   logic wake_now;
   logic step_en;
   logic gate_nxt;

   always_comb begin
      run      = !hold_req;
      step_en  = run && !locked && pd_valid;
      gate_nxt = run && (!locked || wake_now);
   end

   dll_code_step #(.CODE_W(CODE_W)) u_step (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .step_en (step_en),
      .dir_up  (pd_up),
      .code    (dly_code)
   );

   dll_lock_det #(.LOCK_ALT(LOCK_ALT), .WAKE_PER(WAKE_PER)) u_lock (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .run      (run),
      .pd_valid (pd_valid),
      .pd_up    (pd_up),
      .locked   (locked),
      .wake_now (wake_now)
   );

   dll_gate_reg #(.LOW_PHASE(1'b1)) u_gate (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .en_nxt  (gate_nxt),
      .gate_en (gate_en)
   );

endmodule

// File: rtl/dll_code_ctrl_chk.sv
module dll_code_ctrl_chk #(
   parameter int unsigned CODE_W = 8
) (
   input logic              clk_ref,
   input logic              rst_n,
   input logic              pd_valid,
   input logic              pd_up,
   input logic              hold_req,
   input logic [CODE_W-1:0] dly_code,
   input logic              locked,
   input logic              gate_en
);

   localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CMIN = {CODE_W{1'b0}};
   localparam logic [CODE_W-1:0] ONE  = {{(CODE_W-1){1'b0}}, 1'b1};

   // R2: any change of the code is a single step with no wrap
   a_r2_single_step: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (dly_code != $past(dly_code)) |->
         ((dly_code == $past(dly_code) + ONE && $past(dly_code) != CMAX) ||
          (dly_code == $past(dly_code) - ONE && $past(dly_code) != CMIN)));

   // R3
   a_r3_sat_top: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (dly_code == CMAX && pd_valid && pd_up && !hold_req) |=> dly_code == CMAX);

   // R3
   a_r3_sat_bottom: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (dly_code == CMIN && pd_valid && !pd_up && !hold_req) |=> dly_code == CMIN);

   // R4
   a_r4_invalid_no_move: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !pd_valid |=> ($stable(dly_code) && $stable(locked)));

   // R5
   a_r5_hold_freeze: assert property (@(posedge clk_ref) disable iff (!rst_n)
      hold_req |=> ($stable(dly_code) && $stable(locked)));

   // R6: lock only rises on an edge that carried a valid, unheld decision
   a_r6_lock_source: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(locked) |-> ($past(pd_valid) && !$past(hold_req)));

   // R7
   a_r7_code_frozen: assert property (@(posedge clk_ref) disable iff (!rst_n)
      locked |=> $stable(dly_code));

   // R7: the wake pulse is a single edge wide
   a_r7_single_wake: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (locked && gate_en) |=> (!gate_en || !locked));

   // R9
   always @(gate_en) begin
      if (rst_n) begin
         a_r9_gate_low_phase: assert (!clk_ref);
      end
   end

endmodule

bind dll_code_ctrl dll_code_ctrl_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/dll_code_ctrl_tb.sv
module dll_code_ctrl_tb_top;

   localparam int WAKE = 64;
   localparam int ALT  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pd_valid = 1'b0;
   logic       pd_up = 1'b0;
   logic       hold_req = 1'b0;
   logic [7:0] dly_code;
   logic       locked;
   logic       gate_en;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done = 1'b0;
   bit  count_gate = 1'b0;
   int  gate_hi = 0;

   // reference model state
   int m_code = 128;
   bit m_locked = 0;
   bit m_last = 0;
   bit m_have = 0;
   int m_alt = 0;
   int m_wake = 0;
   bit m_wlast = 0;
   bit m_whave = 0;

   always #2 clk = ~clk;

   dll_code_ctrl #(.CODE_W(8), .LOCK_ALT(ALT), .WAKE_PER(WAKE)) dut_i (
      .clk_ref  (clk),
      .rst_n    (rst_n),
      .pd_valid (pd_valid),
      .pd_up    (pd_up),
      .hold_req (hold_req),
      .dly_code (dly_code),
      .locked   (locked),
      .gate_en  (gate_en)
   );

   task automatic chk(input string tag, input bit ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural model, advanced on each rising edge
   always @(posedge clk) begin
      bit wk;
      if (!rst_n) begin
         m_code = 128; m_locked = 0; m_have = 0; m_alt = 0;
         m_wake = 0; m_whave = 0; m_last = 0; m_wlast = 0;
      end else if (!hold_req) begin
         if (!m_locked) begin
            if (pd_valid) begin
               if (pd_up) m_code = (m_code == 255) ? 255 : m_code + 1;
               else       m_code = (m_code == 0) ? 0 : m_code - 1;
               if (m_have && pd_up != m_last) begin
                  m_alt++;
                  if (m_alt == ALT) begin
                     m_locked = 1; m_alt = 0; m_wake = 0; m_whave = 0;
                  end
               end else begin
                  m_alt = 0;
               end
               m_last = pd_up;
               m_have = 1;
            end
         end else begin
            wk = (m_wake == WAKE - 1);
            m_wake = wk ? 0 : m_wake + 1;
            if (wk && pd_valid) begin
               if (m_whave && pd_up == m_wlast) begin
                  m_locked = 0; m_whave = 0; m_have = 0; m_alt = 0;
               end else begin
                  m_wlast = pd_up; m_whave = 1;
               end
            end
         end
      end
   end

   // compare on every cycle in the low phase
   always @(negedge clk) begin
      bit exp_gate;
      #1;
      if (rst_n) begin
         exp_gate = !hold_req && (!m_locked || m_wake == WAKE - 1);
         chk("R2 code vs model", dly_code == 8'(m_code), int'(dly_code), m_code);
         chk("R6 locked vs model", locked == m_locked, int'(locked), int'(m_locked));
         chk("R7 gate_en vs model", gate_en == exp_gate, int'(gate_en), int'(exp_gate));
         if (count_gate && gate_en) gate_hi++;
      end
   end

   // R9: gate_en must not move in the high phase
   always @(gate_en) begin
      if (rst_n && !done) chk("R9 gate_en edge in low phase", clk == 1'b0, int'(clk), 0);
   end

   task automatic drive(input bit v, input bit u, input bit h, input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         pd_valid = v; pd_up = u; hold_req = h;
      end
   endtask

   task automatic settle();
      @(posedge clk); #1;
      pd_valid = 0; hold_req = 0;
      @(negedge clk); #1;
   endtask

   initial begin
      int locked_code;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset code", dly_code == 8'h80, int'(dly_code), 128);
      chk("R1 reset locked", locked == 1'b0, int'(locked), 0);
      chk("R1 reset gate_en", gate_en == 1'b1, int'(gate_en), 1);
      @(posedge clk); #1; rst_n = 1;

      drive(1, 1, 0, 5); settle();
      chk("R2 five ups", dly_code == 8'h85, int'(dly_code), 'h85);
      drive(1, 0, 0, 3); settle();
      chk("R2 three downs", dly_code == 8'h82, int'(dly_code), 'h82);

      for (int i = 0; i < 10; i++) drive(0, i[0], 0, 1);
      settle();
      chk("R4 invalid decisions", dly_code == 8'h82, int'(dly_code), 'h82);

      for (int i = 0; i < 10; i++) drive(1, i[0], 1, 1);
      @(negedge clk); #1;
      chk("R5 hold code", dly_code == 8'h82, int'(dly_code), 'h82);
      chk("R5 hold gate_en", gate_en == 1'b0, int'(gate_en), 0);
      chk("R5 hold no lock", locked == 1'b0, int'(locked), 0);

      drive(1, 1, 0, 200); settle();
      chk("R3 saturate top", dly_code == 8'hFF, int'(dly_code), 255);
      drive(1, 0, 0, 300); settle();
      chk("R3 saturate bottom", dly_code == 8'h00, int'(dly_code), 0);

      drive(1, 1, 0, 100);
      drive(1, 0, 0, 1); drive(1, 1, 0, 1); drive(1, 0, 0, 1); drive(1, 1, 0, 1);
      settle();
      chk("R6 lock after alternations", locked == 1'b1, int'(locked), 1);
      chk("R6 code at lock", dly_code == 8'h64, int'(dly_code), 'h64);
      chk("R7 gate off when locked", gate_en == 1'b0, int'(gate_en), 0);
      locked_code = int'(dly_code);

      count_gate = 1;
      for (int i = 0; i < 300; i++) drive(1, m_whave ? !m_wlast : 1'b0, 0, 1);
      settle();
      count_gate = 0;
      chk("R7 still locked", locked == 1'b1, int'(locked), 1);
      chk("R7 code held", int'(dly_code) == locked_code, int'(dly_code), locked_code);
      chk("R7 wake pulses in 300 cycles", gate_hi >= 4 && gate_hi <= 5, gate_hi, 4);

      drive(1, 1, 1, 70);
      @(negedge clk); #1;
      chk("R5 hold while locked", locked == 1'b1 && gate_en == 1'b0, int'(gate_en), 0);

      drive(1, 1, 0, 250); settle();
      chk("R8 unlock on repeated direction", locked == 1'b0, int'(locked), 0);
      chk("R8 stepping resumed from held code", int'(dly_code) > locked_code,
          int'(dly_code), locked_code + 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1;
         n_err++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule